// File: doc/BRIEF.md
# Masked Module Reset Controller

This block drives a bank of active-low reset lines, one per downstream module, from a 32-bit register interface. Software changes any subset of the reset lines with a single write: the upper half-word of the write data selects which lines the write may touch, and the lower half-word gives the new value for each selected line. A value of 1 releases the module from reset and a value of 0 holds it in reset. Lines whose select bit is 0 keep their state, so separate drivers can share the register without a read-modify-write sequence.

A second read-only register, placed 0x180 bytes above the control register, reports which modules are held in reset right now. Each module must stay in reset for a minimum hold time, measured in rising edges of a slow reference clock (about 32 kHz). The slow clock passes through a two-flop synchroniser into the bus clock domain. If a release write arrives before the hold time has run out, the controller keeps it as pending and carries it out by itself on the slow edge that completes the hold.

Each reset line has its own state machine with four states:
- RELEASED: the line is high.
- HOLDING: the line is low and the hold time is being counted.
- HOLD_PENDING: the line is low, the hold time is being counted, and a release is waiting.
- ARMED: the line is low and the hold time has been met.

Transitions:
- An assert write moves any state to HOLDING and clears the edge count.
- A synchronised slow edge that completes the count moves HOLDING to ARMED, or to RELEASED if a release arrives in the same cycle.
- The same edge moves HOLD_PENDING to RELEASED.
- A release write moves HOLDING to HOLD_PENDING and ARMED to RELEASED.

Top module: `rstc_top`

## Requirements
- R1: After reset, every implemented reset line is high. The control register reads 1 in bits [N_MOD-1:0] and the monitor register reads 0.
- R2: A write to the control offset changes line i only when write bit 16+i is 1. The new control value of that line is write bit i. Lines whose bit 16+i is 0 keep their control value and their output.
- R3: A write with bit 16+i = 1 and bit i = 0 drives line i low. The monitor bit i reads 1 in the cycle after the write clock edge.
- R4: A held line goes high only after HOLD_EDGES synchronised rising edges of the slow clock since its last assert write. A release write to an ARMED line takes effect at the write clock edge.
- R5: A release write that arrives before the hold time is met leaves the line low. The line goes high, with no further write, on the slow edge that completes the hold.
- R6: The monitor register at the control offset + 0x180 reads 1 in bit i while line i is low and 0 once it is released. Its bits always equal the inverse of the reset outputs.
- R7: An assert write to a line that is already holding restarts its edge count from zero.
- R8: Bits at or above N_MOD read 0, and write-enable bits for them have no effect. Writes to the monitor offset are ignored. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| slow_clk | input | 1 | Slow reference clock that times the reset hold (asynchronous) |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data: [31:16] per-line enables, [15:0] per-line values |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mod_rst_n | output | N_MOD | Active-low reset lines, one per module |

## Verification
The bench builds the block with N_MOD = 6 and HOLD_EDGES = 2. With six lines, enable bits 6 to 15 map to no line, so the bench can show that they have no effect and that the unused read bits stay at 0. Two hold edges keep every hold window to two slow-clock pulses. This leaves room to release at exactly the edge count, to stop one edge short, and to restart the count part-way through a hold. Each slow pulse is long enough to pass the synchroniser as exactly one edge, so every expected transition falls at a known clock edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        ST_RELEASED  = 2'd0,
        ST_HOLDING   = 2'd1,
        ST_HOLD_PEND = 2'd2,
        ST_ARMED     = 2'd3
    } rstc_state_e;

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic slow_rise
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= slow_clk;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb slow_rise = sync_q & ~prev_q;

    // R4
    single_edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_rise |=> !slow_rise);

endmodule

// File: rtl/rstc_chan.sv
module rstc_chan
    import rstc_pkg::*;
#(
    parameter int HOLD_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_rise,
    input  logic req_assert,
    input  logic req_release,
    output logic rel_o
);

    localparam int CNT_W = $clog2(HOLD_EDGES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_EDGES - 1);

    rstc_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hold_done;

    always_comb hold_done = slow_rise && (cnt_q == LAST_CNT);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RELEASED: begin
                if (req_assert) begin
                    state_d = ST_HOLDING;
                    cnt_d   = '0;
                end
            end
            ST_HOLDING: begin
                if (req_assert) begin
                    cnt_d = '0;
                end else if (hold_done) begin
                    state_d = req_release ? ST_RELEASED : ST_ARMED;
                end else begin
                    if (slow_rise) cnt_d = cnt_q + 1'b1;
                    if (req_release) state_d = ST_HOLD_PEND;
                end
            end
            ST_HOLD_PEND: begin
                if (req_assert) begin
                    state_d = ST_HOLDING;
                    cnt_d   = '0;
                end else if (hold_done) begin
                    state_d = ST_RELEASED;
                end else if (slow_rise) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ARMED: begin
                if (req_assert) begin
                    state_d = ST_HOLDING;
                    cnt_d   = '0;
                end else if (req_release) begin
                    state_d = ST_RELEASED;
                end
            end
            default: state_d = ST_RELEASED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RELEASED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb rel_o = (state_q == ST_RELEASED);

    // R3
    assert_takes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_assert |=> !rel_o);

    // R4
    no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HOLDING || state_q == ST_HOLD_PEND) && !slow_rise) |=> !rel_o);

    // R5
    release_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_o) |-> ($past(slow_rise) || $past(req_release)));

endmodule

// File: rtl/rstc_top.sv
module rstc_top #(
    parameter int              N_MOD      = 16,
    parameter int              HOLD_EDGES = 2,
    parameter int              ADDR_W     = 12,
    parameter logic [11:0]     CTRL_OFF   = 12'h000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_MOD-1:0]  mod_rst_n
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
    localparam logic [ADDR_W-1:0] MON_A  = ADDR_W'(CTRL_OFF + 12'h180);

    logic             slow_rise;
    logic             wr_hit;
    logic [N_MOD-1:0] en_mask;
    logic [N_MOD-1:0] val_bits;
    logic [N_MOD-1:0] ctrl_q;

    rstc_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_clk  (slow_clk),
        .slow_rise (slow_rise)
    );

    always_comb begin
        wr_hit   = bus_wr && (bus_addr == CTRL_A);
        en_mask  = bus_wdata[16 +: N_MOD];
        val_bits = bus_wdata[0 +: N_MOD];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '1;
        else if (wr_hit) ctrl_q <= (ctrl_q & ~en_mask) | (val_bits & en_mask);
    end

    for (genvar i = 0; i < N_MOD; i++) begin : g_chan
        rstc_chan #(.HOLD_EDGES(HOLD_EDGES)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .slow_rise   (slow_rise),
            .req_assert  (wr_hit && en_mask[i] && !val_bits[i]),
            .req_release (wr_hit && en_mask[i] &&  val_bits[i]),
            .rel_o       (mod_rst_n[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_A)     bus_rdata[N_MOD-1:0] = ctrl_q;
        else if (bus_addr == MON_A) bus_rdata[N_MOD-1:0] = ~mod_rst_n;
    end

    // R2
    masked_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (((ctrl_q ^ $past(ctrl_q)) & ~$past(en_mask)) == '0));

    // R1
    reset_released_chk: assert property (@(posedge clk)
        !rst_n |-> (mod_rst_n == '1));

endmodule

// File: tb/rstc_top_tb_top.sv
`timescale 1ns/100ps
module rstc_top_tb_top;

    localparam int NM = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NM-1:0] mod_rst_n;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    rstc_top #(.N_MOD(NM), .HOLD_EDGES(2), .ADDR_W(12), .CTRL_OFF(12'h000)) dut_i (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mod_rst_n(mod_rst_n)
    );

    localparam logic [31:0] VW [5] = '{32'h0001_0000, 32'h0000_FFFF, 32'h0006_0002,
                                       32'hFFC0_0000, 32'h0001_0001};
    localparam logic [31:0] VC [5] = '{32'h3E, 32'h3E, 32'h3A, 32'h3A, 32'h3B};
    localparam logic [31:0] VM [5] = '{32'h01, 32'h01, 32'h05, 32'h05, 32'h05};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic slow_pulse();
        slow_clk = 1'b1;
        repeat (4) @(negedge clk);
        slow_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_mon(input string req, input logic [31:0] exp);
        logic [31:0] d;
        rd(12'h180, d);
        chk(req, d, exp);
        chk(req, {26'b0, ~mod_rst_n}, exp);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1", {26'b0, mod_rst_n}, 32'h3F);
        rd(12'h000, d); chk("R1", d, 32'h3F);
        rd(12'h180, d); chk("R1", d, 32'h0);

        // R2 R3 R8 table of masked writes
        for (int k = 0; k < 5; k++) begin
            wr(12'h000, VW[k]);
            rd(12'h000, d); chk("R2", d, VC[k]);
            chk_mon("R3", VM[k]);
        end

        // R5 pending release (line 0) completes on the second slow edge
        slow_pulse();
        chk_mon("R5", 32'h05);
        slow_pulse();
        chk_mon("R5", 32'h04);

        // R4 line 2 is armed: release applies at the write edge
        wr(12'h000, 32'h0004_0004);
        chk_mon("R4", 32'h00);

        // R4 one edge is not enough
        wr(12'h000, 32'h0008_0000);
        slow_pulse();
        wr(12'h000, 32'h0008_0008);
        chk_mon("R4", 32'h08);
        slow_pulse();
        chk_mon("R6", 32'h00);

        // R7 re-assert restarts the count
        wr(12'h000, 32'h0010_0000);
        slow_pulse();
        wr(12'h000, 32'h0010_0000);
        slow_pulse();
        wr(12'h000, 32'h0010_0010);
        chk_mon("R7", 32'h10);
        slow_pulse();
        chk_mon("R7", 32'h00);

        // R8 writes to the monitor offset and other offsets are ignored
        wr(12'h180, 32'h003F_0000);
        wr(12'h004, 32'h003F_0000);
        chk_mon("R8", 32'h00);
        rd(12'h000, d); chk("R8", d, 32'h3F);
        rd(12'h004, d); chk("R8", d, 32'h0);

        // R6 several lines held at once
        wr(12'h000, 32'h0021_0000);
        chk_mon("R6", 32'h21);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule